// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Line Controller

The controller turns level changes on general-purpose pins into latched interrupt requests. It provides one line per pin number. Pin x of every input port competes for line x, and a small select field for each line chooses which port's pin x is watched. Each line can react to a low-to-high transition, a high-to-low transition, or both. The two directions are enabled independently.

A detected transition sets a sticky pending flag for the line, whether or not the line is masked. The line asks the processor for service only while its pending flag and its mask bit are both set. Software clears a pending flag by writing a one to its bit position. When a line is moved to a different port, the edge history is reloaded from the new port in the same cycle, so the move alone never looks like an edge.

Pin levels arrive already synchronous to the block clock. Configuration goes through a simple write port and a registered read port.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After a synchronous reset, every register reads zero: all lines select port index 0, all edge enables and mask bits are clear, and no line is pending. `irq_req` and `rd_data` are zero.
- R2: The select registers sit at addresses 4 to 7. Line 4k+j uses bits [4j+1:4j] of address 4+k, and the value in those bits is the index of the port the line watches. Bits [4j+3:4j+2] are not stored and read as zero.
- R3: When bit x of the rising-enable register (address 0) is set, a 0-to-1 change on the selected pin of line x sets pending bit x.
- R4: When bit x of the falling-enable register (address 1) is set, a 1-to-0 change on the selected pin of line x sets pending bit x.
- R5: With both enables set, a line latches on either direction. With neither set, changes on its pin leave pending bit x clear.
- R6: Pending bits (readable at address 3) stay set until they are cleared, whatever the mask says.
- R7: Writing address 3 clears each pending bit whose data bit is 1. Data bits that are 0 leave their pending bits unchanged. If an edge and a clear hit the same line in the same cycle, the pending bit ends up set.
- R8: `irq_req[x]` equals pending bit x ANDed with mask bit x (address 2). It is registered and changes in the same clock cycle as the pending or mask register it depends on.
- R9: Writing a new select value for a line never sets its pending bit, even when the old and new ports carry different levels. Edges on the new port are detected from the next cycle on.
- R10: `rd_data` shows, one clock after the edge, the register that `rd_addr` addressed at that edge.
- R11: Changes on pin x of a port that line x does not select have no effect on that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| port_pins | input | NUM_PORTS*NUM_LINES | Pin levels; port p, pin x at bit p*NUM_LINES+x |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | NUM_LINES | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | NUM_LINES | Registered read data |
| irq_req | output | NUM_LINES | Per-line interrupt request |

## Verification
The bench uses the default build: sixteen lines, four ports and a three-bit address. With these values all four select registers are used, and every port index is a legal choice. Random pin activity on all four ports, mixed with random writes to every address, exercises the following cases:
- selects moving between ports that hold different levels;
- clears that land in the same cycle as new edges;
- mask changes while lines are pending.

A per-cycle reference model checks the results.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  // register address map
  localparam int unsigned ADR_RISE = 0;
  localparam int unsigned ADR_FALL = 1;
  localparam int unsigned ADR_MASK = 2;
  localparam int unsigned ADR_PEND = 3;
  localparam int unsigned ADR_SEL0 = 4;
  // spacing of one select field inside a select register
  localparam int unsigned FIELD_W  = 4;
endpackage

// File: rtl/eil_regfile.sv
module eil_regfile
  import edge_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned ADDR_W    = 3
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   wr_en,
  input  logic [ADDR_W-1:0]                      wr_addr,
  input  logic [NUM_LINES-1:0]                   wr_data,
  input  logic [ADDR_W-1:0]                      rd_addr,
  input  logic [NUM_LINES-1:0]                   pend_q,
  output logic [NUM_LINES-1:0]                   rise_q,
  output logic [NUM_LINES-1:0]                   fall_q,
  output logic [NUM_LINES-1:0]                   mask_q,
  output logic [NUM_LINES-1:0]                   mask_nxt,
  output logic [NUM_LINES*((NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1)-1:0] sel_q,
  output logic [NUM_LINES*((NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1)-1:0] sel_nxt,
  output logic [NUM_LINES-1:0]                   rd_data
);
  localparam int unsigned SEL_W        = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int unsigned LPR          = NUM_LINES / FIELD_W;
  localparam int unsigned NUM_SEL_REGS = NUM_LINES / LPR;

  logic wr_rise, wr_fall, wr_mask;
  logic [NUM_LINES-1:0] sel_word [NUM_SEL_REGS];
  logic [NUM_LINES-1:0] rd_nxt;

  assign wr_rise  = wr_en && (wr_addr == ADDR_W'(ADR_RISE));
  assign wr_fall  = wr_en && (wr_addr == ADDR_W'(ADR_FALL));
  assign wr_mask  = wr_en && (wr_addr == ADDR_W'(ADR_MASK));
  assign mask_nxt = rst ? '0 : (wr_mask ? wr_data : mask_q);

  // next select value per line; forced to port 0 under reset
  always_comb begin
    for (int l = 0; l < int'(NUM_LINES); l++) begin
      if (rst)
        sel_nxt[l*SEL_W +: SEL_W] = '0;
      else if (wr_en && (wr_addr == ADDR_W'(ADR_SEL0 + l / LPR)))
        sel_nxt[l*SEL_W +: SEL_W] = wr_data[(l % LPR)*FIELD_W +: SEL_W];
      else
        sel_nxt[l*SEL_W +: SEL_W] = sel_q[l*SEL_W +: SEL_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      if (wr_rise) rise_q <= wr_data;
      if (wr_fall) fall_q <= wr_data;
    end
    mask_q <= mask_nxt;
    sel_q  <= sel_nxt;
  end

  // read view of select registers, unused field bits read as zero
  always_comb begin
    for (int r = 0; r < int'(NUM_SEL_REGS); r++) begin
      sel_word[r] = '0;
      for (int s = 0; s < int'(LPR); s++)
        sel_word[r][s*FIELD_W +: SEL_W] = sel_q[(r*LPR + s)*SEL_W +: SEL_W];
    end
  end

  always_comb begin
    rd_nxt = '0;
    if (rd_addr == ADDR_W'(ADR_RISE)) rd_nxt = rise_q;
    if (rd_addr == ADDR_W'(ADR_FALL)) rd_nxt = fall_q;
    if (rd_addr == ADDR_W'(ADR_MASK)) rd_nxt = mask_q;
    if (rd_addr == ADDR_W'(ADR_PEND)) rd_nxt = pend_q;
    for (int r = 0; r < int'(NUM_SEL_REGS); r++)
      if (rd_addr == ADDR_W'(ADR_SEL0 + r)) rd_nxt = sel_word[r];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_nxt;
  end

  AST_SEL_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sel_q == '0)) else $error("select not at port 0 after reset"); // R1

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_mask |=> $stable(mask_q)) else $error("mask changed without a write"); // R8
endmodule

// File: rtl/eil_line_sampler.sv
module eil_line_sampler #(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned NUM_PORTS = 4
) (
  input  logic [NUM_PORTS*NUM_LINES-1:0]                                  pins,
  input  logic [NUM_LINES*((NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1)-1:0]  sel,
  output logic [NUM_LINES-1:0]                                            sample
);
  localparam int unsigned SEL_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    logic [SEL_W-1:0] line_sel;
    logic             bit_q;
    assign line_sel = sel[l*SEL_W +: SEL_W];
    always_comb begin
      bit_q = 1'b0;
      for (int p = 0; p < int'(NUM_PORTS); p++)
        if (line_sel == SEL_W'(p)) bit_q = pins[p*NUM_LINES + l];
    end
    assign sample[l] = bit_q;
  end
endmodule

// File: rtl/eil_edge_detect.sv
module eil_edge_detect #(
  parameter int unsigned NUM_LINES = 16
) (
  input  logic                 clk,
  input  logic [NUM_LINES-1:0] cur_sample,
  input  logic [NUM_LINES-1:0] reload_sample,
  input  logic [NUM_LINES-1:0] rise_en,
  input  logic [NUM_LINES-1:0] fall_en,
  output logic [NUM_LINES-1:0] hit
);
  logic [NUM_LINES-1:0] prev_q;

  // history comes from the port selected for the next cycle, so a port
  // change never shows up as a transition
  always_ff @(posedge clk) prev_q <= reload_sample;

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_det
    assign hit[l] = (rise_en[l] &  cur_sample[l] & ~prev_q[l]) |
                    (fall_en[l] & ~cur_sample[l] &  prev_q[l]);
  end
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import edge_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned ADDR_W    = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_PORTS*NUM_LINES-1:0] port_pins,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [NUM_LINES-1:0]           wr_data,
  input  logic [ADDR_W-1:0]              rd_addr,
  output logic [NUM_LINES-1:0]           rd_data,
  output logic [NUM_LINES-1:0]           irq_req
);
  localparam int unsigned SEL_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  logic [NUM_LINES-1:0]       rise_q, fall_q, mask_q, mask_nxt;
  logic [NUM_LINES*SEL_W-1:0] sel_q, sel_nxt;
  logic [NUM_LINES-1:0]       cur_sample, reload_sample, hit;
  logic [NUM_LINES-1:0]       pend_q, pend_nxt, clr_vec;

  eil_regfile #(.NUM_LINES(NUM_LINES), .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .pend_q(pend_q), .rise_q(rise_q), .fall_q(fall_q),
    .mask_q(mask_q), .mask_nxt(mask_nxt), .sel_q(sel_q), .sel_nxt(sel_nxt),
    .rd_data(rd_data)
  );

  eil_line_sampler #(.NUM_LINES(NUM_LINES), .NUM_PORTS(NUM_PORTS)) u_cur_mux (
    .pins(port_pins), .sel(sel_q), .sample(cur_sample)
  );

  eil_line_sampler #(.NUM_LINES(NUM_LINES), .NUM_PORTS(NUM_PORTS)) u_reload_mux (
    .pins(port_pins), .sel(sel_nxt), .sample(reload_sample)
  );

  eil_edge_detect #(.NUM_LINES(NUM_LINES)) u_edges (
    .clk(clk), .cur_sample(cur_sample), .reload_sample(reload_sample),
    .rise_en(rise_q), .fall_en(fall_q), .hit(hit)
  );

  assign clr_vec  = (wr_en && (wr_addr == ADDR_W'(ADR_PEND))) ? wr_data : '0;
  assign pend_nxt = (pend_q & ~clr_vec) | hit;   // new edge wins over clear

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      irq_req <= '0;
    end else begin
      pend_q  <= pend_nxt;
      irq_req <= pend_nxt & mask_nxt;
    end
  end

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && (wr_addr == ADDR_W'(ADR_PEND))) |=> ((pend_q & $past(pend_q)) == $past(pend_q)))
    else $error("pending bit dropped without a clear"); // R6

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    (irq_req & ~mask_q) == '0) else $error("request on a masked line"); // R8

  AST_IRQ_PENDING: assert property (@(posedge clk) disable iff (rst)
    (irq_req & ~pend_q) == '0) else $error("request without pending bit"); // R8
endmodule

// File: tb/edge_irq_ctrl_bench.sv
module edge_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] pins = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data, irq_req;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [15:0] m_rise, m_fall, m_mask, m_pend, m_prev, m_irq, m_rd;
  logic [31:0] m_sel;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_irq_ctrl u_edge_irq_ctrl (
    .clk(clk), .rst(rst), .port_pins(pins), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_req(irq_req)
  );

  function automatic logic [15:0] sample_of(input logic [63:0] pv, input logic [31:0] sv);
    logic [15:0] s;
    for (int l = 0; l < 16; l++) s[l] = pv[int'(sv[l*2 +: 2])*16 + l];
    return s;
  endfunction

  function automatic logic [15:0] read_model(input logic [2:0] a);
    logic [15:0] w;
    w = '0;
    case (a)
      3'd0: w = m_rise;
      3'd1: w = m_fall;
      3'd2: w = m_mask;
      3'd3: w = m_pend;
      default: for (int j = 0; j < 4; j++) w[j*4 +: 2] = m_sel[(int'(a - 3'd4)*4 + j)*2 +: 2];
    endcase
    return w;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: model the edge from pre-edge inputs, then compare outputs
  task automatic cycle(input string tag);
    logic [15:0] cur, hit, clr, n_rise, n_fall, n_mask, n_pend, n_prev, rdv;
    logic [31:0] n_sel;
    if (rst) begin
      n_rise = '0; n_fall = '0; n_mask = '0; n_pend = '0; n_sel = '0; rdv = '0;
      n_prev = sample_of(pins, '0);
    end else begin
      cur = sample_of(pins, m_sel);
      hit = (m_rise & cur & ~m_prev) | (m_fall & ~cur & m_prev);
      rdv = read_model(rd_addr);
      n_rise = (wr_en && wr_addr == 3'd0) ? wr_data : m_rise;
      n_fall = (wr_en && wr_addr == 3'd1) ? wr_data : m_fall;
      n_mask = (wr_en && wr_addr == 3'd2) ? wr_data : m_mask;
      clr    = (wr_en && wr_addr == 3'd3) ? wr_data : '0;
      n_sel  = m_sel;
      if (wr_en && wr_addr >= 3'd4)
        for (int j = 0; j < 4; j++) n_sel[(int'(wr_addr - 3'd4)*4 + j)*2 +: 2] = wr_data[j*4 +: 2];
      n_pend = (m_pend & ~clr) | hit;
      n_prev = sample_of(pins, n_sel);
    end
    @(posedge clk);
    #1;
    m_rise = n_rise; m_fall = n_fall; m_mask = n_mask; m_pend = n_pend;
    m_sel = n_sel; m_prev = n_prev; m_rd = rdv; m_irq = n_pend & n_mask;
    chk({tag, " R8 irq"}, irq_req, m_irq);
    chk({tag, " R10 rd"}, rd_data, m_rd);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input string tag);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cycle(tag);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
    rd_addr = a;
    cycle(tag);
    chk(tag, rd_data, exp);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #1;
    for (int i = 0; i < 4; i++) cycle("reset");
    rst = 1'b0;
    // R1: every register reads zero after reset
    for (int a = 0; a < 8; a++) rd(3'(a), 16'h0000, "R1 reset value");
    chk("R1 irq after reset", irq_req, 16'h0000);

    // R2/R11/R3: line 5 moved to port 2, rising enabled
    wr(3'd5, 16'h0020, "R2 select write");
    rd(3'd5, 16'h0020, "R2 select readback");
    wr(3'd0, 16'h0020, "R3 rise enable");
    pins[5] = 1'b1; cycle("R11");
    rd(3'd3, 16'h0000, "R11 unselected port ignored");
    pins[2*16+5] = 1'b1; cycle("R3");
    rd(3'd3, 16'h0020, "R3 rising edge latched");

    // R7: write-1-clear, write-0 no effect, set beats clear
    wr(3'd3, 16'hFFDF, "R7");
    rd(3'd3, 16'h0020, "R7 zero bit leaves pending");
    wr(3'd3, 16'h0020, "R7");
    rd(3'd3, 16'h0000, "R7 one bit clears pending");
    wr(3'd1, 16'h0020, "R4 fall enable");
    pins[2*16+5] = 1'b0;
    wr(3'd3, 16'h0020, "R7 same-cycle");
    rd(3'd3, 16'h0020, "R7/R4 edge wins over clear");

    // R8/R6: mask gating, pending kept while masked
    chk("R8 masked line quiet", irq_req, 16'h0000);
    wr(3'd2, 16'h0020, "R8 unmask");
    chk("R8 request raised", irq_req, 16'h0020);
    wr(3'd2, 16'h0000, "R8 mask");
    chk("R8 request dropped", irq_req, 16'h0000);
    rd(3'd3, 16'h0020, "R6 pending survives mask");

    // R5: neither enable, then both
    wr(3'd0, 16'h0000, "R5"); wr(3'd1, 16'h0000, "R5"); wr(3'd3, 16'hFFFF, "R5");
    pins[2*16+5] = 1'b1; cycle("R5"); pins[2*16+5] = 1'b0; cycle("R5");
    rd(3'd3, 16'h0000, "R5 no enable no pending");
    wr(3'd0, 16'h0020, "R5"); wr(3'd1, 16'h0020, "R5");
    pins[2*16+5] = 1'b1; cycle("R5");
    rd(3'd3, 16'h0020, "R5 both: rising");
    wr(3'd3, 16'h0020, "R5");
    pins[2*16+5] = 1'b0; cycle("R5");
    rd(3'd3, 16'h0020, "R5 both: falling");

    // R9: move line 5 to port 3 at a different level
    wr(3'd3, 16'hFFFF, "R9");
    pins[3*16+5] = 1'b1; cycle("R9");
    wr(3'd5, 16'h0030, "R9 select port 3");
    cycle("R9");
    rd(3'd3, 16'h0000, "R9 no edge from port change");
    pins[3*16+5] = 1'b0; cycle("R9");
    rd(3'd3, 16'h0020, "R9 new port edge seen");

    // R2: unused field bits read zero
    wr(3'd4, 16'hFFFF, "R2");
    rd(3'd4, 16'h3333, "R2 unused select bits");

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 3) == 0) pins = {$urandom, $urandom};
      else pins[$urandom_range(0, 63)] = ~pins[$urandom_range(0, 63)];
      wr_en   = ($urandom_range(0, 9) < 3);
      wr_addr = 3'($urandom_range(0, 7));
      wr_data = 16'($urandom);
      rd_addr = 3'($urandom_range(0, 7));
      cycle("random");
    end
    wr_en = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule